// File: doc/BRIEF.md
# SPI Target with Address Filter and Transmit Preload

This block is an SPI target (mode 0) that lives on a system clock and treats the serial clock, select and data-in pins as ordinary inputs. It synchronizes them and finds their edges by oversampling. Characters are 8 or 9 bits wide, chosen at run time. Each received character is copied to a receive-data output and raises a receive-complete flag, which software clears by writing 1. Transmit characters enter through a one-deep holding register. A character shifts out of the transmit shift register and is refilled from the holding register at each character boundary.

Two optional behaviours are mutually exclusive. In address mode, the first character of each select-low period is compared with a programmed 8-bit address. On a match, the transaction is accepted and the data-out driver is switched on. On a mismatch, the whole transaction is dropped and the driver stays off. In preload mode, one character moves from the holding register into the transmit shift register while select is high, so the first character of the next transaction carries real data and not a leftover. When both modes are requested, address mode wins and preload is suppressed.

The transmit holding register takes data over a valid/ready handshake. `tx_ready` is high exactly when the register is empty, and a character is taken on a cycle with `tx_valid` and `tx_ready` both high. While the register is full, the writer must hold its data and wait. The register drains only at a character boundary of an accepted transaction, or through preload. The receive side is a plain flag and a data register with no back-pressure. An unread character is overwritten.

Top module: `spi_addr_target`

## Requirements
- R1: After reset, `spi_miso_oe`=0, `rxc_flag`=0, `rx_data`=0 and `tx_ready`=1, and the transmit shift register holds all zeros, so the first character sent without preload is 0.
- R2: Bits move MSB first. Data-in is sampled on rising SCK and data-out changes on falling SCK. Every accepted character is copied to `rx_data` and sets `rxc_flag`. Writing 1 on `rxc_clr` clears the flag.
- R3: With preload off, a transaction first sends the current shift-register contents: zero after reset, otherwise the last character sent. The holding register is loaded only at a character boundary, and it stays full while select is high.
- R4: With preload on (and address mode off), one character moves from the holding register into the shift register while select is high. That character is the first one sent.
- R5: A second character written while select is still high stays in the holding register (`tx_ready`=0) and is sent as the second character.
- R6: In address mode, a first character equal to `addr_match_val` sets `rxc_flag` and turns `spi_miso_oe` on for the rest of the transaction. The following characters are then received and transmitted normally.
- R7: In address mode, a first character that differs drops the transaction until select rises. `rxc_flag` and `rx_data` are unchanged, `spi_miso_oe` stays 0 and the holding register is not drained.
- R8: In 9-bit mode (`frame9`=1), only bits 7:0 of the first character are compared with the address. All 9 bits of accepted characters reach `rx_data`.
- R9: When address mode and preload are both on, no preload happens. `tx_ready` stays 0 while select is high with a character held.
- R10: Raising select mid-character discards the partial character, restarts the bit count and clears the address-match state. The next transaction must match again.
- R11: `spi_miso_oe` is 0 whenever the synchronized select is high.
- R12: When a character is accepted in the same cycle that `rxc_clr` is 1, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame9 | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| addr_mode_en | input | 1 | Enables first-character address filtering |
| preload_en | input | 1 | Enables transmit preload while select is high |
| addr_match_val | input | 8 | Address compared with the first character |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 9 | Transmit character (bits 7:0 used in 8-bit mode) |
| tx_ready | output | 1 | Holding register empty, write accepted |
| rx_data | output | 9 | Last accepted character |
| rxc_flag | output | 1 | Receive-complete flag |
| rxc_clr | input | 1 | Write-1 clear of `rxc_flag` |
| spi_sck | input | 1 | Serial clock |
| spi_ss_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |

## Verification
A character acceptance, which sets `rxc_flag`, can land in the same system-clock cycle as a software clear on `rxc_clr`. The bench times the clear pulse against the final rising SCK of a transaction, counting the synchronizer stages, so that both hit one edge. It then expects the flag to be set. A second run moves the pulse one cycle later and expects the flag to be cleared, which shows the first case was a true collision. Preload and a holding-register write can also meet while select is high. The bench writes a second character right after a preload and expects it to be held and sent second.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int CHAR_MAX = 9;
  localparam int ADDR_W   = 8;
  localparam int CNT_W    = $clog2(CHAR_MAX + 1);

  typedef enum logic [1:0] {
    FILT_IDLE = 2'd0,
    FILT_WAIT = 2'd1,
    FILT_PASS = 2'd2,
    FILT_DROP = 2'd3
  } filt_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
        s3 <= RST_VAL[g];
      end else begin
        s1 <= pin_in[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign level[g] = s2;
    assign rise[g]  = s2 & ~s3;
    assign fall[g]  = ~s2 & s3;
  end
endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter
  import spi_tgt_pkg::*;
#(
  parameter int CW = CHAR_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_sync,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_bit,
  input  logic          frame9,
  input  logic          preload_act,
  input  logic          load_allow,
  input  logic          wr_valid,
  input  logic [CW-1:0] wr_data,
  output logic          wr_ready,
  output logic          miso_bit,
  output logic          char_done,
  output logic [CW-1:0] char_val
);
  logic [CW-1:0]    tx_sh, rx_sh, hold, rot_next;
  logic             hold_full, preloaded;
  logic [CNT_W-1:0] rcnt, fcnt, last_idx;
  logic             active, boundary, do_load, do_pre, wr_fire;

  assign active   = ~ss_sync;
  assign last_idx = frame9 ? CNT_W'(CW - 1) : CNT_W'(CW - 2);

  always_comb begin
    if (frame9) begin
      rot_next = {tx_sh[CW-2:0], tx_sh[CW-1]};
      miso_bit = tx_sh[CW-1];
      char_val = {rx_sh[CW-2:0], mosi_bit};
    end else begin
      rot_next = {1'b0, tx_sh[CW-3:0], tx_sh[CW-2]};
      miso_bit = tx_sh[CW-2];
      char_val = {1'b0, rx_sh[CW-3:0], mosi_bit};
    end
  end

  assign char_done = active && sck_rise && (rcnt == last_idx);
  assign boundary  = active && sck_fall && (fcnt == last_idx);
  assign do_load   = boundary && load_allow && hold_full;
  assign do_pre    = ss_sync && preload_act && hold_full && !preloaded;
  assign wr_ready  = ~hold_full;
  assign wr_fire   = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (do_load || do_pre) begin
      hold_full <= 1'b0;
    end else if (wr_fire) begin
      hold      <= wr_data;
      hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (do_pre || do_load) begin
      tx_sh <= hold;
    end else if (active && sck_fall) begin
      tx_sh <= rot_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preloaded <= 1'b0;
    end else if (active) begin
      preloaded <= 1'b0;
    end else if (do_pre) begin
      preloaded <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt  <= '0;
      fcnt  <= '0;
      rx_sh <= '0;
    end else if (!active) begin
      rcnt <= '0;
      fcnt <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh <= {rx_sh[CW-2:0], mosi_bit};
        rcnt  <= (rcnt == last_idx) ? '0 : rcnt + 1'b1;
      end
      if (sck_fall) begin
        fcnt <= (fcnt == last_idx) ? '0 : fcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tgt_addr_filt.sv
module spi_tgt_addr_filt
  import spi_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_sync,
  input  logic              addr_mode,
  input  logic              char_done,
  input  logic [ADDR_W-1:0] char_low,
  input  logic [ADDR_W-1:0] addr_val,
  output logic              accept,
  output logic              oe_allow,
  output logic              load_allow,
  output logic              drop_st
);
  filt_e st, eff, st_next;
  logic  hit;

  assign hit = (char_low == addr_val);
  assign eff = (st == FILT_IDLE) ? (addr_mode ? FILT_WAIT : FILT_PASS) : st;

  always_comb begin
    if (ss_sync)                          st_next = FILT_IDLE;
    else if (char_done && eff == FILT_WAIT) st_next = hit ? FILT_PASS : FILT_DROP;
    else                                  st_next = eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= FILT_IDLE;
    else        st <= st_next;
  end

  assign accept     = char_done && ((eff == FILT_PASS) || (eff == FILT_WAIT && hit));
  assign oe_allow   = (st == FILT_PASS);
  assign load_allow = (eff == FILT_PASS);
  assign drop_st    = (st == FILT_DROP);
endmodule

// File: rtl/spi_addr_target.sv
module spi_addr_target
  import spi_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame9,
  input  logic              addr_mode_en,
  input  logic              preload_en,
  input  logic [ADDR_W-1:0] addr_match_val,
  input  logic              tx_valid,
  input  logic [CHAR_MAX-1:0] tx_data,
  output logic              tx_ready,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic              rxc_flag,
  input  logic              rxc_clr,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b100;

  logic [NPIN-1:0] lvl, rs, fl;
  logic ss_sync, sck_rise, sck_fall, mosi_bit;
  logic char_done, accept, oe_allow, load_allow, filt_drop, miso_bit;
  logic [CHAR_MAX-1:0] char_val;

  spi_tgt_sync #(.N(NPIN), .RST_VAL(PIN_RST)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .pin_in({spi_ss_n, spi_sck, spi_mosi}),
    .level(lvl), .rise(rs), .fall(fl)
  );

  assign ss_sync  = lvl[2];
  assign sck_rise = rs[1];
  assign sck_fall = fl[1];
  assign mosi_bit = lvl[0];

  spi_tgt_shifter #(.CW(CHAR_MAX)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .ss_sync(ss_sync), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_bit(mosi_bit), .frame9(frame9),
    .preload_act(preload_en & ~addr_mode_en),
    .load_allow(load_allow),
    .wr_valid(tx_valid), .wr_data(tx_data), .wr_ready(tx_ready),
    .miso_bit(miso_bit), .char_done(char_done), .char_val(char_val)
  );

  spi_tgt_addr_filt filt_i (
    .clk(clk), .rst_n(rst_n),
    .ss_sync(ss_sync), .addr_mode(addr_mode_en),
    .char_done(char_done), .char_low(char_val[ADDR_W-1:0]),
    .addr_val(addr_match_val),
    .accept(accept), .oe_allow(oe_allow),
    .load_allow(load_allow), .drop_st(filt_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_flag <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (accept) begin
        rxc_flag <= 1'b1;
        rx_data  <= char_val;
      end else if (rxc_clr) begin
        rxc_flag <= 1'b0;
      end
    end
  end

  assign spi_miso    = miso_bit;
  assign spi_miso_oe = ~ss_sync & oe_allow;
endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk
  import spi_tgt_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                ss_sync,
  input logic                char_done,
  input logic                accept,
  input logic                filt_drop,
  input logic                rxc_flag,
  input logic [CHAR_MAX-1:0] rx_data,
  input logic                miso_oe,
  input logic                tx_valid,
  input logic                tx_ready,
  input logic                addr_mode_en
);
  a_r11_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ss_sync |-> !miso_oe);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rxc_flag);

  a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxc_flag) |-> $past(accept));

  a_r7_drop_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && filt_drop) |=> $stable(rx_data));

  a_r7_drop_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    filt_drop |-> !miso_oe);

  a_r9_no_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode_en && ss_sync && !tx_ready) |=> !tx_ready);

  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind spi_addr_target spi_tgt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ss_sync(ss_sync), .char_done(char_done),
  .accept(accept), .filt_drop(filt_drop), .rxc_flag(rxc_flag),
  .rx_data(rx_data), .miso_oe(spi_miso_oe), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .addr_mode_en(addr_mode_en)
);

// File: tb/spi_addr_target_tb_top.sv
module spi_addr_target_tb_top;
  localparam int H = 4;

  logic clk = 0, rst_n = 0;
  logic frame9 = 0, addr_mode_en = 0, preload_en = 0;
  logic [7:0] addr_match_val = 8'h6D;
  logic tx_valid = 0;
  logic [8:0] tx_data = '0;
  logic tx_ready, rxc_flag, spi_miso, spi_miso_oe;
  logic [8:0] rx_data;
  logic rxc_clr = 0, spi_sck = 0, spi_ss_n = 1, spi_mosi = 0;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [8:0] mo [4];
  logic [8:0] mi [4];
  logic       oe_any [4];
  logic [8:0] exp_rx;

  always #5 clk = ~clk;

  spi_addr_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame9(frame9), .addr_mode_en(addr_mode_en),
    .preload_en(preload_en), .addr_match_val(addr_match_val),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_data(rx_data), .rxc_flag(rxc_flag), .rxc_clr(rxc_clr),
    .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk); tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); rxc_clr = 1;
    @(negedge clk); rxc_clr = 0;
  endtask

  // n characters; nbits>0 cuts the transfer after nbits bits of char 0
  task automatic xfer(input int n, input int nbits, input int clr_at);
    int w = frame9 ? 9 : 8;
    int bits = (nbits > 0) ? nbits : w;
    spi_ss_n = 0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < n; c++) begin
      mi[c] = '0; oe_any[c] = 0;
      for (int b = 0; b < bits; b++) begin
        spi_mosi = mo[c][w-1-b];
        repeat (H) @(negedge clk);
        mi[c] = {mi[c][7:0], spi_miso};
        oe_any[c] = oe_any[c] | spi_miso_oe;
        spi_sck = 1;
        for (int k = 1; k <= H; k++) begin
          @(negedge clk);
          if (c == n-1 && b == bits-1) rxc_clr = (k == clr_at);
        end
        rxc_clr = 0;
        spi_sck = 0;
      end
    end
    repeat (H) @(negedge clk);
    spi_ss_n = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(spi_miso_oe == 0 && rxc_flag == 0 && rx_data == 0 && tx_ready == 1, "R1 reset",
        {spi_miso_oe, rxc_flag, tx_ready, rx_data}, {3'b001, 9'h000});

    // R3 without preload, data waits while select high
    wr(9'h0A5);
    repeat (5) @(negedge clk);
    chk(tx_ready == 0, "R3 held while idle", tx_ready, 0);
    mo[0] = 9'h03C; mo[1] = 9'h081;
    xfer(2, 0, 0);
    chk(mi[0][7:0] == 8'h00, "R1 first char zero", mi[0], 0);
    chk(mi[1][7:0] == 8'hA5, "R3 load at boundary", mi[1], 9'h0A5);
    chk(rx_data == 9'h081 && rxc_flag, "R2 receive", rx_data, 9'h081);
    chk(oe_any[1] == 1, "R2 oe in normal mode", oe_any[1], 1);
    clear_flag();
    chk(rxc_flag == 0, "R2 write-1 clear", rxc_flag, 0);

    // R2/R3 sweep: every byte received, last char resent
    for (int v = 0; v < 256; v++) begin
      mo[0] = 9'(v);
      xfer(1, 0, 0);
      chk(rx_data == 9'(v) && rxc_flag && mi[0][7:0] == 8'hA5, "R2 R3 sweep",
          {rx_data, mi[0]}, {9'(v), 9'h0A5});
      clear_flag();
    end

    // R4/R5 preload
    preload_en = 1;
    wr(9'h05A);
    repeat (5) @(negedge clk);
    chk(tx_ready == 1, "R4 preload drained", tx_ready, 1);
    wr(9'h0C3);
    repeat (5) @(negedge clk);
    chk(tx_ready == 0, "R5 second held", tx_ready, 0);
    mo[0] = 9'h011; mo[1] = 9'h022;
    xfer(2, 0, 0);
    chk(mi[0][7:0] == 8'h5A, "R4 first char preloaded", mi[0], 9'h05A);
    chk(mi[1][7:0] == 8'hC3, "R5 second char", mi[1], 9'h0C3);
    chk(tx_ready == 1, "R5 drained", tx_ready, 1);
    exp_rx = 9'h022;
    clear_flag();

    // R6/R7/R9 address sweep with preload also requested
    addr_mode_en = 1;
    for (int c = 0; c < 256; c++) begin
      if (tx_ready) begin
        wr(9'h099);
        repeat (5) @(negedge clk);
        chk(tx_ready == 0, "R9 preload suppressed", tx_ready, 0);
      end
      mo[0] = 9'(c); mo[1] = 9'h042;
      xfer(2, 0, 0);
      if (c == 8'h6D) begin
        chk(rxc_flag && rx_data == 9'h042, "R6 match accepted", rx_data, 9'h042);
        chk(oe_any[0] == 0 && oe_any[1] == 1, "R6 oe after match", {oe_any[0], oe_any[1]}, 2'b01);
        chk(mi[1][7:0] == 8'h99, "R6 data sent", mi[1], 9'h099);
        exp_rx = 9'h042;
        clear_flag();
      end else begin
        chk(!rxc_flag && rx_data == exp_rx && !oe_any[0] && !oe_any[1] && !tx_ready,
            "R7 mismatch dropped", {rxc_flag, rx_data}, {1'b0, exp_rx});
      end
    end

    // R8 9-bit frames
    frame9 = 1;
    mo[0] = 9'h16D; mo[1] = 9'h1AB;
    xfer(2, 0, 0);
    chk(rxc_flag && rx_data == 9'h1AB, "R8 low byte match", rx_data, 9'h1AB);
    clear_flag();
    mo[0] = 9'h06C; mo[1] = 9'h155;
    xfer(2, 0, 0);
    chk(!rxc_flag && rx_data == 9'h1AB, "R8 mismatch", rx_data, 9'h1AB);
    mo[0] = 9'h06D; mo[1] = 9'h0F0;
    xfer(2, 0, 0);
    chk(rxc_flag && rx_data == 9'h0F0, "R8 bit8 clear match", rx_data, 9'h0F0);
    clear_flag();
    frame9 = 0;

    // R10 abort and fresh matching
    mo[0] = 9'h06D;
    xfer(1, 3, 0);
    chk(!rxc_flag, "R10 partial ignored", rxc_flag, 0);
    mo[0] = 9'h06D; mo[1] = 9'h033;
    xfer(2, 0, 0);
    chk(rxc_flag && rx_data == 9'h033, "R10 count restarted", rx_data, 9'h033);
    clear_flag();
    mo[0] = 9'h010; mo[1] = 9'h077;
    xfer(2, 0, 0);
    chk(!rxc_flag && rx_data == 9'h033, "R10 match state cleared", rx_data, 9'h033);
    addr_mode_en = 0;
    preload_en = 0;
    mo[0] = 9'h1FF;
    xfer(1, 5, 0);
    mo[0] = 9'h03C;
    xfer(1, 0, 0);
    chk(rx_data == 9'h03C, "R10 normal abort", rx_data, 9'h03C);
    clear_flag();

    // R11 idle oe
    chk(spi_miso_oe == 0, "R11 oe off when idle", spi_miso_oe, 0);

    // R12 set and clear in the same cycle
    mo[0] = 9'h001; mo[1] = 9'h002;
    xfer(2, 0, 2);
    chk(rxc_flag == 1 && rx_data == 9'h002, "R12 set wins", rxc_flag, 1);
    clear_flag();
    mo[0] = 9'h003; mo[1] = 9'h004;
    xfer(2, 0, 3);
    chk(rxc_flag == 0 && rx_data == 9'h004, "R12 later clear", rxc_flag, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule